// File: doc/BRIEF.md
# CAN controller register and interrupt front end

This block is the software-visible face of a CAN controller. It sits on a simple 32-bit register bus and holds the operating mode, a write-only action register, a status word, an interrupt enable mask, the latched interrupt flags and the two error counters. The protocol core next to it supplies single-cycle event pulses, status levels, an error capture code and counter step pulses. It receives back the mode bits and one-shot action pulses.

After reset the block is held in configuration (reset) mode. The acceptance-filter layout bit and the sleep bit can only be changed while that bit is set. Software enables the events it cares about, services the single interrupt line and clears the handled flags by writing ones to them. Actions such as transmit, abort or releasing the receive buffer are written as bits that leave the block as single-cycle pulses and are never stored.

Register offsets: 0x00 mode, 0x04 command, 0x08 status, 0x0C interrupt flags, 0x10 interrupt enable, 0x1C error counters. Reads of other offsets return 0.

Top module: `canctl_regs`

## Requirements
- R1: While reset is asserted, the registers read as follows: mode reads 0x00000001, status reads 0x0000003C, and flags, enable and error counters read 0. The outputs irq_o and cmd_o are 0.
- R2: The mode register has these bits: bit 0 configuration (reset) mode, bit 1 listen-only, bit 2 loopback, bit 3 single filter, bit 4 sleep. Bits 0 to 2 take any write. Bits 3 and 4 take a write only if bit 0 was 1 before that write, and otherwise keep their value. The mode bits drive mode_o.
- R3: A write to offset 0x04 places wdata[5:0] on cmd_o for exactly the one cycle after the write edge; cmd_o is 0 otherwise. Offset 0x04 reads as 0. The cmd_o bits are: 0 transmit, 1 abort, 2 release receive buffer, 3 clear overrun, 4 self-receive, 5 bus-off request.
- R4: Status bits 0 and 2 to 7 show core_sts one clock after it is presented. Status bit 1 (overrun) sets on the overrun event (core_evt bit 3) whatever the enable mask holds. It clears on a command write with bit 3 set. When that event and that command fall in the same cycle, the event wins.
- R5: Status bits [23:16] load core_err_code on the bus error event (core_evt bit 7), whatever the enable mask holds, and hold otherwise. The layout is [23:22] error type, [21] direction, [20:16] frame segment.
- R6: Interrupt flag bit i sets when core_evt bit i pulses while enable bit i is 1. With enable bit i at 0 the pulse leaves the flag at 0. The shared layout is: 0 receive, 1 transmit done, 2 error warning, 3 overrun, 4 wakeup, 5 error passive, 6 arbitration lost, 7 bus error.
- R7: Writing a value to offset 0x0C clears exactly the flags whose bits are 1 in it and leaves the others unchanged.
- R8: If an enabled event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: irq_o is 1 exactly when any flag is set. A set flag stays set until it is cleared, even if its enable bit is cleared.
- R10: The transmit error count is at offset 0x1C bits [7:0] and the receive error count at bits [23:16]. Each count steps up or down by one on its inc or dec pulse and saturates at 255 and at 0. Inc and dec together leave it unchanged. A write loads both fields, so writing 0 clears them, and a write overrides any pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while bus_sel is high and bus_wr is low |
| core_evt | input | 8 | Event pulses from the protocol core, flag layout |
| core_sts | input | 8 | Status levels from the core (bit 1 unused) |
| core_err_code | input | 8 | Error capture code, type/direction/segment |
| tec_inc | input | 1 | Transmit error count up |
| tec_dec | input | 1 | Transmit error count down |
| rec_inc | input | 1 | Receive error count up |
| rec_dec | input | 1 | Receive error count down |
| mode_o | output | 5 | Mode bits to the core |
| cmd_o | output | 6 | One-shot action pulses to the core |
| irq_o | output | 1 | Interrupt request |

## Verification
An event pulse and a software clear can land on the same flip-flop in one cycle. This happens for an interrupt flag, where an enabled event meets a write-one-to-clear, and for the overrun status bit, where the overrun event meets the clear-overrun command. The bench drives the event input and the bus write in the same half-cycle, so both reach the same clock edge. It then reads the register back and expects the bit still set. A second, lone clear must then drop it, which shows the earlier result came from the event taking priority.

// File: rtl/canctl_pkg.sv
package canctl_pkg;
  localparam int unsigned OFS_MODE = 'h00;
  localparam int unsigned OFS_CMD  = 'h04;
  localparam int unsigned OFS_STAT = 'h08;
  localparam int unsigned OFS_FLAG = 'h0C;
  localparam int unsigned OFS_EN   = 'h10;
  localparam int unsigned OFS_ERRC = 'h1C;

  localparam int unsigned MODE_W   = 5;
  localparam int unsigned MB_CFG   = 0;
  localparam int unsigned MB_FLT   = 3;
  localparam int unsigned MB_SLP   = 4;

  localparam int unsigned CMD_W    = 6;
  localparam int unsigned CB_OVCLR = 3;

  localparam int unsigned NUM_EVT  = 8;
  localparam int unsigned EV_OVR   = 3;
  localparam int unsigned EV_BERR  = 7;

  localparam int unsigned STS_W    = 8;
  localparam logic [7:0]  STS_RST  = 8'h3C;
  localparam int unsigned REC_LSB  = 16;

  typedef enum logic [2:0] {
    RS_NONE, RS_MODE, RS_CMD, RS_STAT, RS_FLAG, RS_EN, RS_ERRC
  } regsel_e;
endpackage

// File: rtl/canctl_mode.sv
module canctl_mode
  import canctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wdata,
  output logic [MODE_W-1:0] mode_q
);
  logic [MODE_W-1:0] mode_d;
  logic              cfg_open;

  assign cfg_open = mode_q[MB_CFG];

  always_comb begin
    mode_d = mode_q;
    if (wr_en) begin
      for (int b = 0; b < MODE_W; b++) begin
        if ((b != MB_FLT && b != MB_SLP) || cfg_open) mode_d[b] = wdata[b];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_W'(1);
    else        mode_q <= mode_d;
  end

  // R2: gated bits keep their value outside configuration mode
  p_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !mode_q[MB_CFG]) |=>
      (mode_q[MB_SLP:MB_FLT] == $past(mode_q[MB_SLP:MB_FLT])));

  p_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (mode_q[2:0] == $past(wdata[2:0])));
endmodule

// File: rtl/canctl_irq.sv
module canctl_irq #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         en_wr,
  input  logic         flag_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] en_q,
  output logic [N-1:0] flag_q,
  output logic         irq
);
  logic [N-1:0] en_d;
  logic [N-1:0] flag_d;

  always_comb en_d = en_wr ? wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_flag
    logic set_i, clr_i;
    assign set_i = evt[i] & en_q[i];
    assign clr_i = flag_wr & wdata[i];

    always_comb flag_d[i] = set_i | (flag_q[i] & ~clr_i);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    p_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt[i] && en_q[i]) |=> flag_q[i]);
    p_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag_q[i] && !(evt[i] && en_q[i])) |=> !flag_q[i]);
    p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wdata[i] && !(evt[i] && en_q[i])) |=> !flag_q[i]);
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_wr && wdata[i] && evt[i] && en_q[i]) |=> flag_q[i]);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !(flag_wr && wdata[i])) |=> flag_q[i]);
  end

  assign irq = |flag_q;
endmodule

// File: rtl/canctl_stat.sv
module canctl_stat
  import canctl_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] core_sts,
  input  logic             ovr_evt,
  input  logic             ovr_clr,
  input  logic             berr_evt,
  input  logic [7:0]       err_code,
  input  logic             tec_inc,
  input  logic             tec_dec,
  input  logic             rec_inc,
  input  logic             rec_dec,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] tec_w,
  input  logic [CNT_W-1:0] rec_w,
  output logic [STS_W-1:0] stat_q,
  output logic [7:0]       ecc_q,
  output logic [CNT_W-1:0] tec_q,
  output logic [CNT_W-1:0] rec_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [STS_W-1:0] stat_d;
  logic [7:0]       ecc_d;
  logic [CNT_W-1:0] tec_d, rec_d;
  logic             ovr_d;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v,
                                            input logic up, input logic dn);
    if (up && !dn && v != CNT_MAX)      return v + 1'b1;
    else if (dn && !up && v != '0)      return v - 1'b1;
    else                                return v;
  endfunction

  always_comb begin
    ovr_d  = ovr_evt | (stat_q[1] & ~ovr_clr);
    stat_d = {core_sts[STS_W-1:2], ovr_d, core_sts[0]};
    ecc_d  = berr_evt ? err_code : ecc_q;
    tec_d  = cnt_wr ? tec_w : step(tec_q, tec_inc, tec_dec);
    rec_d  = cnt_wr ? rec_w : step(rec_q, rec_inc, rec_dec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STS_RST;
      ecc_q  <= '0;
      tec_q  <= '0;
      rec_q  <= '0;
    end else begin
      stat_q <= stat_d;
      ecc_q  <= ecc_d;
      tec_q  <= tec_d;
      rec_q  <= rec_d;
    end
  end

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> stat_q[1]);
  p_ovr_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_clr && !ovr_evt) |=> !stat_q[1]);
  p_ecc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !berr_evt |=> $stable(ecc_q));
  p_cnt_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (tec_q == $past(tec_w) && rec_q == $past(rec_w)));
  p_tec_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tec_q == CNT_MAX && tec_inc && !cnt_wr) |=> (tec_q == CNT_MAX));
  p_rec_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_q == '0 && rec_dec && !cnt_wr) |=> (rec_q == '0));
endmodule

// File: rtl/canctl_regs.sv
module canctl_regs
  import canctl_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NUM_EVT-1:0] core_evt,
  input  logic [STS_W-1:0]  core_sts,
  input  logic [7:0]        core_err_code,
  input  logic              tec_inc,
  input  logic              tec_dec,
  input  logic              rec_inc,
  input  logic              rec_dec,
  output logic [MODE_W-1:0] mode_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic              irq_o
);
  logic [1:0] rsync;
  logic       rst_n;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rsync <= 2'b00;
    else         rsync <= {rsync[0], 1'b1};
  end
  assign rst_n = rsync[1];

  regsel_e sel;
  always_comb begin
    sel = RS_NONE;
    if (bus_sel) begin
      if      (bus_addr == ADDR_W'(OFS_MODE)) sel = RS_MODE;
      else if (bus_addr == ADDR_W'(OFS_CMD))  sel = RS_CMD;
      else if (bus_addr == ADDR_W'(OFS_STAT)) sel = RS_STAT;
      else if (bus_addr == ADDR_W'(OFS_FLAG)) sel = RS_FLAG;
      else if (bus_addr == ADDR_W'(OFS_EN))   sel = RS_EN;
      else if (bus_addr == ADDR_W'(OFS_ERRC)) sel = RS_ERRC;
    end
  end

  logic mode_wr, cmd_wr, flag_wr, en_wr, cnt_wr;
  assign mode_wr = bus_wr && sel == RS_MODE;
  assign cmd_wr  = bus_wr && sel == RS_CMD;
  assign flag_wr = bus_wr && sel == RS_FLAG;
  assign en_wr   = bus_wr && sel == RS_EN;
  assign cnt_wr  = bus_wr && sel == RS_ERRC;

  logic [CMD_W-1:0] cmd_d, cmd_q;
  always_comb cmd_d = cmd_wr ? bus_wdata[CMD_W-1:0] : '0;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_d;
  end
  assign cmd_o = cmd_q;

  p_cmd_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (cmd_o == '0));
  p_cmd_fire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (cmd_o == $past(bus_wdata[CMD_W-1:0])));

  logic [MODE_W-1:0] mode_q;
  canctl_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr),
    .wdata(bus_wdata[MODE_W-1:0]), .mode_q(mode_q)
  );
  assign mode_o = mode_q;

  logic [NUM_EVT-1:0] en_q, flag_q;
  canctl_irq #(.N(NUM_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt(core_evt), .en_wr(en_wr),
    .flag_wr(flag_wr), .wdata(bus_wdata[NUM_EVT-1:0]),
    .en_q(en_q), .flag_q(flag_q), .irq(irq_o)
  );

  logic [STS_W-1:0] stat_q;
  logic [7:0]       ecc_q;
  logic [CNT_W-1:0] tec_q, rec_q;
  canctl_stat #(.CNT_W(CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .core_sts(core_sts),
    .ovr_evt(core_evt[EV_OVR]),
    .ovr_clr(cmd_wr && bus_wdata[CB_OVCLR]),
    .berr_evt(core_evt[EV_BERR]), .err_code(core_err_code),
    .tec_inc(tec_inc), .tec_dec(tec_dec),
    .rec_inc(rec_inc), .rec_dec(rec_dec),
    .cnt_wr(cnt_wr), .tec_w(bus_wdata[CNT_W-1:0]),
    .rec_w(bus_wdata[REC_LSB +: CNT_W]),
    .stat_q(stat_q), .ecc_q(ecc_q), .tec_q(tec_q), .rec_q(rec_q)
  );

  logic unused_wbits;
  assign unused_wbits = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (!bus_wr) begin
      unique case (sel)
        RS_MODE: bus_rdata = 32'(mode_q);
        RS_STAT: bus_rdata = {8'h00, ecc_q, 8'h00, stat_q};
        RS_FLAG: bus_rdata = 32'(flag_q);
        RS_EN:   bus_rdata = 32'(en_q);
        RS_ERRC: bus_rdata = (32'(rec_q) << REC_LSB) | 32'(tec_q);
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/canctl_regs_test.sv
`timescale 1ns/1ps
module canctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        bus_sel, bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [7:0]  core_evt, core_sts, core_err_code;
  logic        tec_inc, tec_dec, rec_inc, rec_dec;
  logic [4:0]  mode_o;
  logic [5:0]  cmd_o;
  logic        irq_o;

  always #5 clk = ~clk;

  canctl_regs uut (
    .clk(clk), .rst_ni(rst_ni), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_evt(core_evt), .core_sts(core_sts), .core_err_code(core_err_code),
    .tec_inc(tec_inc), .tec_dec(tec_dec), .rec_inc(rec_inc), .rec_dec(rec_dec),
    .mode_o(mode_o), .cmd_o(cmd_o), .irq_o(irq_o)
  );

  typedef struct {
    int          kind;
    logic [31:0] v;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 0;
  event  smp;

  // monitor: pops expected items and compares with the outputs
  always @(smp) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    case (it.kind)
      0:       act = bus_rdata;
      1:       act = {31'b0, irq_o};
      2:       act = {26'b0, cmd_o};
      default: act = {27'b0, mode_o};
    endcase
    n_chk++;
    if (act !== it.v) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.v);
    end
  end

  task automatic expect_out(input int kind, input logic [31:0] v, input string tag);
    item_t it;
    it.kind = kind; it.v = v; it.tag = tag;
    q.push_back(it);
    #1 -> smp;
    #1;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] v, input string tag);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    expect_out(0, v, tag);
    bus_sel = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic pulse(input logic [7:0] e);
    @(negedge clk);
    core_evt = e;
    @(negedge clk);
    core_evt = '0;
  endtask

  task automatic steps(input int n, input logic ti, input logic td,
                       input logic ri, input logic rdn);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      tec_inc = ti; tec_dec = td; rec_inc = ri; rec_dec = rdn;
    end
    @(negedge clk);
    tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    core_evt = '0; core_sts = '0; core_err_code = '0;
    tec_inc = 0; tec_dec = 0; rec_inc = 0; rec_dec = 0;
    repeat (3) @(negedge clk);
    // R1 reset state, observed while reset is held
    rd(8'h00, 32'h1,  "R1 mode");
    rd(8'h08, 32'h3C, "R1 status");
    rd(8'h0C, 32'h0,  "R1 flags");
    rd(8'h10, 32'h0,  "R1 enable");
    rd(8'h1C, 32'h0,  "R1 errc");
    expect_out(1, 0, "R1 irq");
    expect_out(2, 0, "R1 cmd");
    @(negedge clk); rst_ni = 1;
    repeat (4) @(negedge clk);

    // R2 mode gating
    wr(8'h00, 32'h19); rd(8'h00, 32'h19, "R2 cfg write");
    expect_out(3, 32'h19, "R2 mode_o");
    wr(8'h00, 32'h18); rd(8'h00, 32'h18, "R2 leave cfg");
    wr(8'h00, 32'h06); rd(8'h00, 32'h1E, "R2 gated ignored");
    wr(8'h00, 32'h01); rd(8'h00, 32'h19, "R2 reenter cfg");
    wr(8'h00, 32'h00); rd(8'h00, 32'h00, "R2 cfg clear");

    // R3 command pulses
    wr(8'h04, 32'h2A);
    expect_out(2, 32'h2A, "R3 pulse");
    @(negedge clk);
    expect_out(2, 32'h00, "R3 one cycle");
    rd(8'h04, 32'h0, "R3 reads zero");

    // R4 status mirror and overrun
    core_sts = 8'hA5; @(negedge clk);
    rd(8'h08, 32'hA5, "R4 mirror");
    pulse(8'h08);
    rd(8'h08, 32'hA7, "R4 ovr set");
    wr(8'h04, 32'h08);
    rd(8'h08, 32'hA5, "R4 ovr clr");
    pulse(8'h08);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h04; bus_wdata = 32'h08; core_evt = 8'h08;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; core_evt = 0;
    rd(8'h08, 32'hA7, "R4 event wins");
    wr(8'h04, 32'h08);
    rd(8'h08, 32'hA5, "R4 lone clear");

    // R5 error capture
    core_err_code = 8'hC5; pulse(8'h80);
    rd(8'h08, 32'h00C500A5, "R5 capture");
    core_err_code = 8'h3A; @(negedge clk);
    rd(8'h08, 32'h00C500A5, "R5 hold");
    rd(8'h0C, 32'h0, "R6 disabled no flag");
    expect_out(1, 0, "R6 irq low");

    // R6 flag set under enable
    wr(8'h10, 32'hFF);
    pulse(8'h42);
    rd(8'h0C, 32'h42, "R6 flags set");
    expect_out(1, 1, "R9 irq high");

    // R7 write-one-to-clear
    wr(8'h0C, 32'h02);
    rd(8'h0C, 32'h40, "R7 partial clear");

    // R8 event against clear
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h0C; bus_wdata = 32'h40; core_evt = 8'h40;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; core_evt = 0;
    rd(8'h0C, 32'h40, "R8 event wins");
    wr(8'h0C, 32'h40);
    rd(8'h0C, 32'h00, "R8 lone clear");
    expect_out(1, 0, "R9 irq low");

    // R9 sticky across enable change
    pulse(8'h01);
    wr(8'h10, 32'h00);
    rd(8'h0C, 32'h01, "R9 sticky");
    expect_out(1, 1, "R9 irq kept");
    wr(8'h0C, 32'h01);
    expect_out(1, 0, "R9 irq cleared");

    // R10 error counters
    steps(3, 1, 0, 0, 0);
    steps(2, 0, 0, 1, 0);
    rd(8'h1C, 32'h00020003, "R10 increments");
    steps(4, 1, 1, 1, 1);
    rd(8'h1C, 32'h00020003, "R10 inc+dec hold");
    wr(8'h1C, 32'h0);
    rd(8'h1C, 32'h0, "R10 clear");
    steps(2, 0, 1, 0, 1);
    rd(8'h1C, 32'h0, "R10 floor");
    wr(8'h1C, 32'h00FE00FD);
    steps(5, 1, 0, 1, 0);
    rd(8'h1C, 32'h00FF00FF, "R10 saturate");
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 8'h1C; bus_wdata = 32'h00100020; tec_inc = 1;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tec_inc = 0;
    rd(8'h1C, 32'h00100020, "R10 write wins");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule